// File: doc/BRIEF.md
# System Memory Region Guard

The region guard sits on the request path between the bus managers of a chip, such as processor cores and DMA engines, and a shared memory or peripheral space. Every request carries the ID of the manager that issued it and a virtual-machine tag. The guard compares the request address against a table of regions. Each region is a naturally aligned power-of-two window with a base address, a size exponent and three allow masks (read, write, execute) that hold one bit per virtual-machine tag. Because rights are keyed by tag and not by processor privilege, one table polices every manager in the system, and register ranges of peripherals are assigned the same way as memory ranges.

A permitted request goes through unchanged, in the same cycle. A denied request never appears on the forwarded channel. It is accepted at once, answered with an error pulse routed to the issuing manager, and recorded in a sticky fault record that also serves as the interrupt line. Only one designated hypervisor manager may write the table or clear the fault record. Writes from any other manager are dropped and flagged.

Top module: `region_guard`

## Requirements
- R1: After synchronous reset, every region is disabled, the fault record is empty (flt_valid low), err_rsp_valid and cfg_viol are low, and every request is therefore denied.
- R2: A region with size exponent k (0 to 63) covers 2^k bytes. It matches an address when the address and the region base agree in every bit from position k upward. The low k bits of the base are ignored, and k of 32 or more matches the whole address space.
- R3: The access type is encoded on req_kind as 0 read, 1 write, 2 execute, and 3 reserved, which is always denied. A request is granted when at least one enabled region that matches it has bit req_vmid set in the mask for that access type.
- R4: An address that matches no enabled region is denied, whatever its tag or type.
- R5: A granted request appears on the forward channel in the same cycle with address, data, type, tag and manager unchanged. Its req_ready then follows fwd_ready, so a stalled target stalls the requester.
- R6: A denied request keeps fwd_valid low and sees req_ready high in the same cycle. One cycle later, err_rsp_valid pulses for exactly one cycle with err_rsp_mgr equal to the requester's manager ID.
- R7: The first denial while the fault record is empty captures its address, tag, manager and type and raises flt_valid. The record then holds unchanged through later denials.
- R8: A hypervisor write to the control address (cfg_addr bit 6 set) empties the fault record in the next cycle. If a denial arrives in that same cycle, the clear wins and that denial is not recorded.
- R9: Configuration writes whose cfg_mgr differs from the hypervisor ID (default 0) change neither the region table nor the fault record. Each such write pulses cfg_viol for one cycle, one cycle later.
- R10: With cfg_addr bit 6 clear, bits 5:2 select the region and bits 1:0 select the field: 0 is the base address, 1 is the size exponent in bits 5:0 with the enable in bit 8, 2 is the read mask in bits 15:0 with the write mask in bits 31:16, and 3 is the execute mask in bits 15:0. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Incoming request accepted |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | DATA_W | Request write data |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| req_vmid | input | 4 | Virtual-machine tag of the request |
| req_mgr | input | 3 | Issuing manager ID |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_ready | input | 1 | Target accepts the forwarded request |
| fwd_addr | output | 32 | Forwarded address |
| fwd_wdata | output | DATA_W | Forwarded write data |
| fwd_kind | output | 2 | Forwarded access type |
| fwd_vmid | output | 4 | Forwarded tag |
| fwd_mgr | output | 3 | Forwarded manager ID |
| err_rsp_valid | output | 1 | One-cycle error response for a blocked request |
| err_rsp_mgr | output | 3 | Manager that receives the error response |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mgr | input | 3 | Manager ID of the configuration writer |
| cfg_addr | input | 7 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_viol | output | 1 | Pulse: a configuration write was refused |
| flt_valid | output | 1 | Fault record holds a denial (interrupt level) |
| flt_addr | output | 32 | Recorded fault address |
| flt_vmid | output | 4 | Recorded fault tag |
| flt_mgr | output | 3 | Recorded fault manager |
| flt_kind | output | 2 | Recorded fault access type |

## Verification
The assertions take for granted that the request and configuration inputs are driven to known values in every cycle after reset, and that a configuration write and a request may share a cycle. The error and fault properties rely on a denied request being accepted in the same cycle it is presented. The stimulus drives every input on the falling edge, so each value is stable at the rising edge. It sets the request fields on every cycle, including idle ones, and deliberately lines a fault clear up with a denial to exercise the shared-cycle case.

// File: rtl/region_guard_pkg.sv
`timescale 1ns/1ps
package region_guard_pkg;

    localparam int unsigned RG_ADDR_W = 32;
    localparam int unsigned RG_VMID_W = 4;
    localparam int unsigned RG_NUM_VM = 1 << RG_VMID_W;
    localparam int unsigned RG_MGR_W  = 3;
    localparam int unsigned RG_CFG_W  = 32;
    localparam int unsigned RG_LG_W   = 6;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic                 en;
        logic [RG_LG_W-1:0]   lg;
        logic [RG_ADDR_W-1:0] base;
        logic [RG_NUM_VM-1:0] rd;
        logic [RG_NUM_VM-1:0] wr;
        logic [RG_NUM_VM-1:0] ex;
    } region_t;

    typedef struct packed {
        logic [RG_ADDR_W-1:0] addr;
        logic [RG_VMID_W-1:0] vmid;
        logic [RG_MGR_W-1:0]  mgr;
        acc_kind_e            kind;
    } fault_t;

    // ones below bit position lg: the offset bits inside a window
    function automatic logic [RG_ADDR_W-1:0] low_mask(input logic [RG_LG_W-1:0] lg);
        logic [RG_ADDR_W-1:0] m;
        for (int i = 0; i < RG_ADDR_W; i++) begin
            m[i] = ($unsigned(i) < 32'(lg));
        end
        return m;
    endfunction

    function automatic logic region_hit(input region_t r, input logic [RG_ADDR_W-1:0] a);
        return r.en && (((a ^ r.base) & ~low_mask(r.lg)) == '0);
    endfunction

    function automatic logic [RG_NUM_VM-1:0] rights_of(input region_t r, input acc_kind_e k);
        case (k)
            ACC_READ:  return r.rd;
            ACC_WRITE: return r.wr;
            ACC_EXEC:  return r.ex;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/rg_cfg_regs.sv
`timescale 1ns/1ps
module rg_cfg_regs
    import region_guard_pkg::*;
#(
    parameter int unsigned NUM_REG = 16,
    parameter int unsigned HYP_MGR = 0,
    localparam int unsigned IDX_W  = $clog2(NUM_REG),
    localparam int unsigned CAW    = IDX_W + 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [RG_MGR_W-1:0] cfg_mgr,
    input  logic [CAW-1:0]      cfg_addr,
    input  logic [RG_CFG_W-1:0] cfg_wdata,
    output region_t             regions [NUM_REG],
    output logic                fault_clr,
    output logic                cfg_viol
);

    logic hyp_wr;
    logic tbl_wr;

    assign hyp_wr    = cfg_we && (cfg_mgr == RG_MGR_W'(HYP_MGR));
    assign fault_clr = hyp_wr && cfg_addr[CAW-1];
    assign tbl_wr    = hyp_wr && !cfg_addr[CAW-1];

    for (genvar g = 0; g < NUM_REG; g++) begin : g_region
        always_ff @(posedge clk) begin
            if (rst) begin
                regions[g] <= '0;
            end else if (tbl_wr && (cfg_addr[CAW-2:2] == IDX_W'(g))) begin
                case (cfg_addr[1:0])
                    2'd0: regions[g].base <= cfg_wdata[RG_ADDR_W-1:0];
                    2'd1: begin
                        regions[g].lg <= cfg_wdata[RG_LG_W-1:0];
                        regions[g].en <= cfg_wdata[8];
                    end
                    2'd2: begin
                        regions[g].rd <= cfg_wdata[RG_NUM_VM-1:0];
                        regions[g].wr <= cfg_wdata[16 +: RG_NUM_VM];
                    end
                    default: regions[g].ex <= cfg_wdata[RG_NUM_VM-1:0];
                endcase
            end
        end

        AST_FOREIGN_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && (cfg_mgr != RG_MGR_W'(HYP_MGR))) |=> $stable(regions[g])); // R9
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_viol <= 1'b0;
        else     cfg_viol <= cfg_we && !hyp_wr;
    end

    AST_FOREIGN_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_mgr != RG_MGR_W'(HYP_MGR))) |=> cfg_viol); // R9

endmodule

// File: rtl/rg_lookup.sv
`timescale 1ns/1ps
module rg_lookup
    import region_guard_pkg::*;
#(
    parameter int unsigned NUM_REG = 16
) (
    input  region_t              regions [NUM_REG],
    input  logic [RG_ADDR_W-1:0] addr,
    input  acc_kind_e            kind,
    input  logic [RG_VMID_W-1:0] vmid,
    output logic                 grant
);

    logic [NUM_REG-1:0] pass;

    for (genvar g = 0; g < NUM_REG; g++) begin : g_match
        logic [RG_NUM_VM-1:0] allow_v;
        assign allow_v = rights_of(regions[g], kind);
        assign pass[g] = region_hit(regions[g], addr) && allow_v[vmid];
    end

    assign grant = |pass;

endmodule

// File: rtl/rg_fault.sv
`timescale 1ns/1ps
module rg_fault
    import region_guard_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                deny_hs,
    input  fault_t              info,
    input  logic                clr,
    output logic                err_rsp,
    output logic [RG_MGR_W-1:0] err_mgr,
    output logic                flt_valid,
    output fault_t              flt_rec
);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_rsp   <= 1'b0;
            err_mgr   <= '0;
            flt_valid <= 1'b0;
            flt_rec   <= '0;
        end else begin
            err_rsp <= deny_hs;
            if (deny_hs) err_mgr <= info.mgr;
            if (clr) begin
                flt_valid <= 1'b0;
            end else if (deny_hs && !flt_valid) begin
                flt_valid <= 1'b1;
                flt_rec   <= info;
            end
        end
    end

    AST_ERR_AFTER_DENY: assert property (@(posedge clk) disable iff (rst)
        deny_hs |=> (err_rsp && (err_mgr == $past(info.mgr)))); // R6
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && !clr) |=> (flt_valid && $stable(flt_rec))); // R7
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flt_valid); // R8

endmodule

// File: rtl/region_guard.sv
`timescale 1ns/1ps
module region_guard
    import region_guard_pkg::*;
#(
    parameter int unsigned NUM_REG = 16,
    parameter int unsigned HYP_MGR = 0,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned IDX_W  = $clog2(NUM_REG),
    localparam int unsigned CAW    = IDX_W + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [RG_ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [1:0]           req_kind,
    input  logic [RG_VMID_W-1:0] req_vmid,
    input  logic [RG_MGR_W-1:0]  req_mgr,
    output logic                 fwd_valid,
    input  logic                 fwd_ready,
    output logic [RG_ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0]    fwd_wdata,
    output logic [1:0]           fwd_kind,
    output logic [RG_VMID_W-1:0] fwd_vmid,
    output logic [RG_MGR_W-1:0]  fwd_mgr,
    output logic                 err_rsp_valid,
    output logic [RG_MGR_W-1:0]  err_rsp_mgr,
    input  logic                 cfg_we,
    input  logic [RG_MGR_W-1:0]  cfg_mgr,
    input  logic [CAW-1:0]       cfg_addr,
    input  logic [RG_CFG_W-1:0]  cfg_wdata,
    output logic                 cfg_viol,
    output logic                 flt_valid,
    output logic [RG_ADDR_W-1:0] flt_addr,
    output logic [RG_VMID_W-1:0] flt_vmid,
    output logic [RG_MGR_W-1:0]  flt_mgr,
    output logic [1:0]           flt_kind
);

    region_t   regions [NUM_REG];
    logic      fault_clr;
    logic      grant;
    logic      deny_hs;
    acc_kind_e kind_e;
    fault_t    info;
    fault_t    flt_rec;

    assign kind_e = acc_kind_e'(req_kind);

    rg_cfg_regs #(.NUM_REG(NUM_REG), .HYP_MGR(HYP_MGR)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_mgr   (cfg_mgr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .regions   (regions),
        .fault_clr (fault_clr),
        .cfg_viol  (cfg_viol)
    );

    rg_lookup #(.NUM_REG(NUM_REG)) u_lookup (
        .regions (regions),
        .addr    (req_addr),
        .kind    (kind_e),
        .vmid    (req_vmid),
        .grant   (grant)
    );

    // granted: pass through, back-pressure from target; denied: absorb now
    assign fwd_valid = req_valid && grant;
    assign req_ready = grant ? fwd_ready : 1'b1;
    assign fwd_addr  = req_addr;
    assign fwd_wdata = req_wdata;
    assign fwd_kind  = req_kind;
    assign fwd_vmid  = req_vmid;
    assign fwd_mgr   = req_mgr;
    assign deny_hs   = req_valid && !grant;

    assign info = '{addr: req_addr, vmid: req_vmid, mgr: req_mgr, kind: kind_e};

    rg_fault u_fault (
        .clk       (clk),
        .rst       (rst),
        .deny_hs   (deny_hs),
        .info      (info),
        .clr       (fault_clr),
        .err_rsp   (err_rsp_valid),
        .err_mgr   (err_rsp_mgr),
        .flt_valid (flt_valid),
        .flt_rec   (flt_rec)
    );

    assign flt_addr = flt_rec.addr;
    assign flt_vmid = flt_rec.vmid;
    assign flt_mgr  = flt_rec.mgr;
    assign flt_kind = flt_rec.kind;

    AST_ERR_ONLY_FOR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        err_rsp_valid |-> $past(req_valid && !fwd_valid && req_ready)); // R6
    AST_STALL_HOLDS_REQUESTER: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && !fwd_ready) |-> !req_ready); // R5

endmodule

// File: tb/region_guard_tb_top.sv
`timescale 1ns/1ps
module region_guard_tb_top;
    import region_guard_pkg::*;

    localparam int NREG = 16;
    localparam int HYP  = 0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    always #10 clk = ~clk;

    logic        req_valid, req_ready, fwd_valid, fwd_ready;
    logic [31:0] req_addr, req_wdata, fwd_addr, fwd_wdata;
    logic [1:0]  req_kind, fwd_kind, flt_kind;
    logic [3:0]  req_vmid, fwd_vmid, flt_vmid;
    logic [2:0]  req_mgr, fwd_mgr, err_rsp_mgr, cfg_mgr, flt_mgr;
    logic        err_rsp_valid, cfg_we, cfg_viol, flt_valid;
    logic [6:0]  cfg_addr;
    logic [31:0] cfg_wdata, flt_addr;

    region_guard dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_kind(req_kind), .req_vmid(req_vmid), .req_mgr(req_mgr),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr),
        .fwd_wdata(fwd_wdata), .fwd_kind(fwd_kind), .fwd_vmid(fwd_vmid), .fwd_mgr(fwd_mgr),
        .err_rsp_valid(err_rsp_valid), .err_rsp_mgr(err_rsp_mgr),
        .cfg_we(cfg_we), .cfg_mgr(cfg_mgr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_viol(cfg_viol), .flt_valid(flt_valid), .flt_addr(flt_addr),
        .flt_vmid(flt_vmid), .flt_mgr(flt_mgr), .flt_kind(flt_kind)
    );

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    logic [31:0] m_base [NREG];
    int          m_lg   [NREG];
    bit          m_en   [NREG];
    logic [15:0] m_rd [NREG], m_wr [NREG], m_ex [NREG];
    bit          e_err, e_viol, e_fv;
    logic [2:0]  e_emgr, e_fmgr;
    logic [31:0] e_faddr;
    logic [3:0]  e_fvm;
    logic [1:0]  e_fk;

    task automatic check(string r, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    function automatic bit allow(logic [31:0] a, int kind, int vm);
        for (int i = 0; i < NREG; i++) begin
            logic [15:0] msk;
            bit inside_w;
            if (!m_en[i]) continue;
            inside_w = (m_lg[i] >= 32) ? 1'b1 : ((a >> m_lg[i]) == (m_base[i] >> m_lg[i]));
            if (!inside_w) continue;
            msk = (kind == 0) ? m_rd[i] : (kind == 1) ? m_wr[i] : (kind == 2) ? m_ex[i] : 16'h0;
            if (msk[vm]) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) begin
            m_base[i] = '0; m_lg[i] = 0; m_en[i] = 0; m_rd[i] = '0; m_wr[i] = '0; m_ex[i] = '0;
        end
        e_err = 0; e_viol = 0; e_fv = 0; e_emgr = '0;
        e_faddr = '0; e_fvm = '0; e_fmgr = '0; e_fk = '0;
    endtask

    // one clock: compare same-cycle outputs, step model, compare registered outputs
    task automatic tick();
        bit ok, dhs, hyp, clr;
        int idx;
        #1;
        ok = allow(req_addr, int'(req_kind), int'(req_vmid));
        check(ok ? "R5" : "R6", "fwd_valid", fwd_valid, req_valid && ok);
        check(ok ? "R5" : "R6", "req_ready", req_ready, ok ? fwd_ready : 1'b1);
        if (req_valid && ok) begin
            check("R5", "fwd_addr", fwd_addr, req_addr);
            check("R5", "fwd_wdata", fwd_wdata, req_wdata);
            check("R5", "fwd_tag", {fwd_kind, fwd_vmid, fwd_mgr}, {req_kind, req_vmid, req_mgr});
        end
        dhs = req_valid && !ok;
        @(posedge clk);
        hyp = cfg_we && (cfg_mgr == 3'(HYP));
        clr = hyp && cfg_addr[6];
        e_err = dhs;
        if (dhs) e_emgr = req_mgr;
        e_viol = cfg_we && !hyp;
        if (hyp && !cfg_addr[6]) begin
            idx = int'(cfg_addr[5:2]);
            case (cfg_addr[1:0])
                2'd0: m_base[idx] = cfg_wdata;
                2'd1: begin m_lg[idx] = int'(cfg_wdata[5:0]); m_en[idx] = cfg_wdata[8]; end
                2'd2: begin m_rd[idx] = cfg_wdata[15:0]; m_wr[idx] = cfg_wdata[31:16]; end
                default: m_ex[idx] = cfg_wdata[15:0];
            endcase
        end
        if (clr) e_fv = 0;
        else if (dhs && !e_fv) begin
            e_fv = 1; e_faddr = req_addr; e_fvm = req_vmid; e_fmgr = req_mgr; e_fk = req_kind;
        end
        @(negedge clk);
        check("R6", "err_rsp_valid", err_rsp_valid, e_err);
        if (e_err) check("R6", "err_rsp_mgr", err_rsp_mgr, e_emgr);
        check("R9", "cfg_viol", cfg_viol, e_viol);
        check(clr ? "R8" : "R7", "flt_valid", flt_valid, e_fv);
        if (e_fv) check("R7", "fault_record", {flt_addr, flt_vmid, flt_mgr, flt_kind},
                        {e_faddr, e_fvm, e_fmgr, e_fk});
    endtask

    task automatic set_idle();
        req_valid = 0; req_addr = '0; req_wdata = '0; req_kind = '0; req_vmid = '0; req_mgr = '0;
        fwd_ready = 1; cfg_we = 0; cfg_mgr = '0; cfg_addr = '0; cfg_wdata = '0;
    endtask

    task automatic cfg_wr(int mgr, int idx, int field, logic [31:0] data);
        set_idle();
        cfg_we = 1; cfg_mgr = 3'(mgr); cfg_addr = {1'b0, 4'(idx), 2'(field)}; cfg_wdata = data;
        tick();
        set_idle();
    endtask

    task automatic clr_wr(int mgr);
        set_idle();
        cfg_we = 1; cfg_mgr = 3'(mgr); cfg_addr = 7'h40; cfg_wdata = '0;
        tick();
        set_idle();
    endtask

    task automatic program_region(int idx, logic [31:0] base, int lg,
                                  logic [15:0] rd, logic [15:0] wr, logic [15:0] ex);
        cfg_wr(HYP, idx, 0, base);
        cfg_wr(HYP, idx, 2, {wr, rd});
        cfg_wr(HYP, idx, 3, {16'h0, ex});
        cfg_wr(HYP, idx, 1, 32'h100 | 32'(lg));
    endtask

    // request with an explicitly computed expected grant
    task automatic req(string r, bit exp_grant, logic [31:0] a, int kind, int vm, int mgr);
        set_idle();
        req_valid = 1; req_addr = a; req_wdata = a ^ 32'h5A5A_0F0F;
        req_kind = 2'(kind); req_vmid = 4'(vm); req_mgr = 3'(mgr);
        #1;
        check(r, "grant", fwd_valid, exp_grant);
        tick();
        set_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        set_idle();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1", "flt_valid", flt_valid, 0);
        check("R1", "err_rsp_valid", err_rsp_valid, 0);
        check("R1", "cfg_viol", cfg_viol, 0);

        // R1 / R4: empty table denies everything; first denial recorded
        req("R1", 0, 32'h1000_0000, 0, 1, 2);
        check("R7", "fault_addr", flt_addr, 32'h1000_0000);
        req("R4", 0, 32'h5555_0000, 1, 3, 4);
        check("R7", "fault_addr_held", flt_addr, 32'h1000_0000);
        // R9: foreign manager cannot clear the record
        clr_wr(1);
        check("R9", "flt_valid_after_foreign_clear", flt_valid, 1);
        clr_wr(HYP);
        check("R8", "flt_valid_after_clear", flt_valid, 0);

        // R10: program the table through the register map
        program_region(0,  32'h1000_0000, 12, 16'h0002, 16'h0002, 16'h0000);
        program_region(1,  32'h2000_0000, 16, 16'h000C, 16'h0004, 16'h0000);
        program_region(7,  32'h3000_0000, 0,  16'h0010, 16'h0000, 16'h0000);
        program_region(15, 32'h0000_0000, 32, 16'h0000, 16'h0000, 16'h0020);

        req("R2", 1, 32'h1000_0000, 0, 1, 1);
        req("R2", 1, 32'h1000_0FFF, 0, 1, 1);
        req("R2", 0, 32'h1000_1000, 0, 1, 6);
        check("R7", "fault_addr", flt_addr, 32'h1000_1000);
        check("R7", "fault_mgr", flt_mgr, 3'd6);
        req("R2", 0, 32'h0FFF_FFFF, 0, 1, 1);
        req("R3", 1, 32'h1000_0800, 1, 1, 1);
        req("R3", 0, 32'h1000_0000, 2, 1, 1);
        req("R3", 0, 32'h1000_0004, 0, 2, 1);
        req("R3", 1, 32'h7000_0000, 2, 5, 3);
        req("R3", 0, 32'h1000_0000, 3, 1, 1);
        req("R2", 1, 32'h3000_0000, 0, 4, 2);
        req("R2", 0, 32'h3000_0001, 0, 4, 2);
        req("R3", 0, 32'h2000_1234, 1, 3, 2);
        req("R3", 1, 32'h2000_1234, 0, 3, 2);
        req("R4", 0, 32'h9000_0000, 0, 1, 1);
        check("R7", "fault_addr_still_first", flt_addr, 32'h1000_1000);

        // R5: target stall holds the requester
        set_idle();
        req_valid = 1; req_addr = 32'h1000_0010; req_vmid = 4'd1; fwd_ready = 0;
        #1;
        check("R5", "req_ready_stalled", req_ready, 0);
        tick();
        check("R5", "no_err_on_stall", err_rsp_valid, 0);
        set_idle();

        // R9: foreign write to disable region 0 is dropped
        cfg_wr(3, 0, 1, 32'h0);
        req("R9", 1, 32'h1000_0000, 0, 1, 1);

        // R8: clear and a denial in the same cycle: clear wins
        set_idle();
        cfg_we = 1; cfg_mgr = 3'(HYP); cfg_addr = 7'h40;
        req_valid = 1; req_addr = 32'hA000_0000; req_vmid = 4'd9;
        tick();
        check("R8", "clear_beats_capture", flt_valid, 0);
        set_idle();
        req("R7", 0, 32'hB000_0000, 1, 7, 5);
        check("R7", "fault_vmid", flt_vmid, 4'd7);
        check("R7", "fault_kind", flt_kind, 2'd1);

        // mixed traffic against the model
        for (int n = 0; n < 600; n++) begin
            int sel;
            set_idle();
            sel = int'($urandom_range(0, 3));
            req_valid = ($urandom_range(0, 3) != 0);
            req_addr  = (sel == 0) ? (32'h1000_0000 | 32'($urandom_range(0, 32'h1FFF))) :
                        (sel == 1) ? (32'h2000_0000 | 32'($urandom_range(0, 32'h1FFFF))) :
                        (sel == 2) ? (32'h3000_0000 | 32'($urandom_range(0, 3))) : $urandom;
            req_wdata = $urandom;
            req_kind  = 2'($urandom_range(0, 3));
            req_vmid  = 4'($urandom_range(0, 15));
            req_mgr   = 3'($urandom_range(0, 7));
            fwd_ready = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 9) == 0) begin
                cfg_we = 1; cfg_mgr = 3'($urandom_range(0, 3)); cfg_addr = 7'h40;
            end else if ($urandom_range(0, 9) == 0) begin
                cfg_we = 1; cfg_mgr = 3'($urandom_range(1, 7));
                cfg_addr = 7'($urandom_range(0, 63)); cfg_wdata = $urandom;
            end
            tick();
        end
        set_idle();
        tick();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule